// File: doc/BRIEF.md
# Mode-Dependent Alternate-Function I/O Port

An eight-pin general-purpose port that sits on a simple byte-wide memory-mapped bus. Software sees three registers: a direction register that can only be written, an output data register that can be written and read back, and a pin-state register that can only be read. Each pin has a data output and a tri-state enable toward its pad, and a pad input that passes through a two-flop synchronizer before anything reads it.

Two mode pins select one of four operating modes. In the single-chip mode every pin is ordinary I/O controlled by its direction bit. In the three external-bus modes the port hands pins over to other functions. Pin 7 drives the system clock when its direction bit is set. Pins 6 to 3 always carry the four bus-control strobes from the bus controller, whatever their direction bits hold. Pins 2 to 0 belong to the bus controller while its per-pin enable is high, and act as ordinary I/O otherwise. The reset value of the direction register depends on the mode. A power-on reset or hardware standby loads it. A manual reset or software standby leaves it alone. During software standby, a hold control decides whether the bus-control pins keep their last levels or float.

Top module: `altfn_port`

## Requirements
- R1: After power-on reset (`rstPorN` low), the data register reads 0x00. The direction register holds 0x80 in the external-bus modes (`modePins` 00, 01, 10) and 0x00 in the single-chip mode (`modePins` 11), which shows at the ports as `pinOe` = 0xF8 in mode 00 with `bcLowEn` = 0, and as `pinOe` = 0x00 in mode 11.
- R2: While `hwStandby` is high, the direction register is loaded with its mode-dependent reset value at every clock edge, and bus writes to it have no effect.
- R3: A low `manualRstN` clears the data register to 0x00 at the next clock edge and leaves the direction register unchanged. A software standby does not change the direction register.
- R4: In the single-chip mode (`modePins` = 11), `pinOe[i]` equals direction bit i and `pinOut[i]` equals data bit i for every pin, and `bcLowEn` has no effect.
- R5: In an external-bus mode, `pinOut[7]` follows `sysClk` and `pinOe[7]` equals direction bit 7.
- R6: In an external-bus mode outside software standby, `pinOe[6:3]` is 0xF and `pinOut[6:3]` equals `bcOut[3:0]`, whatever direction bits 6 to 3 hold.
- R7: In an external-bus mode, a pin i in 2..0 with `bcLowEn[i]` high takes `pinOe[i]` from `bcLowOe[i]` and `pinOut[i]` from `bcLowOut[i]`. With `bcLowEn[i]` low, it takes them from direction bit i and data bit i.
- R8: During software standby (`swStandby` high) in an external-bus mode, bus-owned pins 6 to 0 keep the enables and levels they had at the last clock edge before standby when `holdOutputs` is high, and have `pinOe` low when `holdOutputs` is low.
- R9: A write with `busWrEn` high takes effect at the clock edge that samples it: address 0xFEBE writes the direction register, and 0xFF6E writes the data register. Other addresses change nothing. With `busRdEn` high, `busRdData` in the same cycle is the data register at 0xFF6E, 0xFF at 0xFEBE, and 0x00 elsewhere.
- R10: A read of 0xFF5E returns, for each pin that is ordinary I/O with its direction bit set, the data register bit, and for every other pin the pad level from the two-flop synchronizer. A pad change becomes visible after the second clock edge. `bcLowIn` is the synchronized level of pins 2 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rstPorN | input | 1 | Power-on reset, active low, asynchronous |
| manualRstN | input | 1 | Manual reset, active low, synchronous; clears data only |
| hwStandby | input | 1 | Hardware standby; forces the direction register to its reset value |
| swStandby | input | 1 | Software standby |
| holdOutputs | input | 1 | In software standby: 1 holds bus-control outputs, 0 floats them |
| modePins | input | 2 | Operating mode: 00/01/10 external bus, 11 single chip |
| busAddr | input | 16 | Lower 16 address bits |
| busWrEn | input | 1 | Write strobe |
| busRdEn | input | 1 | Read strobe |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data, same cycle |
| sysClk | input | 1 | System clock to be driven on pin 7 |
| bcOut | input | 4 | Bus-control strobe levels for pins 6 to 3 |
| bcLowEn | input | 3 | Bus-controller ownership enables for pins 2 to 0 |
| bcLowOe | input | 3 | Bus-controller output enables for pins 2 to 0 |
| bcLowOut | input | 3 | Bus-controller output levels for pins 2 to 0 |
| bcLowIn | output | 3 | Synchronized levels of pins 2 to 0 for the bus controller |
| pinIn | input | 8 | Pad input levels |
| pinOut | output | 8 | Pad output levels |
| pinOe | output | 8 | Pad tri-state enables, 1 drives |

## Verification
On every cycle the checker confirms the per-pin ownership rules that depend only on present inputs and register contents. These rules are the single-chip pass-through, the clock pin, the forced enables of the strobe pins, and the floating of bus pins in standby. It also checks the register-update rules across one edge: data writes, manual-reset clearing, direction retention, and the hardware-standby reload. The two-edge synchronizer latency and the read-back mix of data and pad bits in the pin-state register can only be shown by the bench's scenarios. So can the mode-dependent power-on values and the capture of held levels across a standby entry.

// File: rtl/altfn_port_pkg.sv
package altfn_port_pkg;

  localparam int PORT_W    = 8;
  localparam int CLK_PIN   = 7;
  localparam int BC_HI     = 6;
  localparam int BC_LO     = 3;
  localparam int BC_OUT_W  = BC_HI - BC_LO + 1;
  localparam int SHARED_W  = BC_LO;

  localparam logic [1:0] MODE_SINGLE = 2'b11;

  localparam logic [PORT_W-1:0] DIR_RST_EXT    = 8'h80;
  localparam logic [PORT_W-1:0] DIR_RST_SINGLE = 8'h00;
  localparam logic [PORT_W-1:0] DIR_RD_FILL    = 8'hFF;

  typedef enum logic [1:0] {
    RD_NONE = 2'd0,
    RD_DIR  = 2'd1,
    RD_DATA = 2'd2,
    RD_PINS = 2'd3
  } rdSel_e;

  typedef struct packed {
    logic   wrDir;
    logic   wrData;
    rdSel_e rdSel;
  } portStrobes_t;

endpackage

// File: rtl/altfn_port_ctrl.sv
module altfn_port_ctrl
  import altfn_port_pkg::*;
#(
  parameter int               ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] DIR_ADDR  = 16'hFEBE,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 16'hFF6E,
  parameter logic [ADDR_W-1:0] PIN_ADDR  = 16'hFF5E
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  output portStrobes_t      strobes
);

  logic hitDir, hitData, hitPins;

  assign hitDir  = (busAddr == DIR_ADDR);
  assign hitData = (busAddr == DATA_ADDR);
  assign hitPins = (busAddr == PIN_ADDR);

  always_comb begin
    strobes        = '0;
    strobes.wrDir  = busWrEn && hitDir;
    strobes.wrData = busWrEn && hitData;
    strobes.rdSel  = RD_NONE;
    if (busRdEn) begin
      if (hitDir)       strobes.rdSel = RD_DIR;
      else if (hitData) strobes.rdSel = RD_DATA;
      else if (hitPins) strobes.rdSel = RD_PINS;
    end
  end

endmodule

// File: rtl/altfn_port_dp.sv
module altfn_port_dp
  import altfn_port_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstPorN,
  input  logic                manualRstN,
  input  logic                hwStandby,
  input  logic                swStandby,
  input  logic                holdOutputs,
  input  logic [1:0]          modePins,
  input  portStrobes_t        strobes,
  input  logic [PORT_W-1:0]   wrData,
  output logic [PORT_W-1:0]   rdData,
  input  logic                sysClk,
  input  logic [BC_OUT_W-1:0] bcOut,
  input  logic [SHARED_W-1:0] bcLowEn,
  input  logic [SHARED_W-1:0] bcLowOe,
  input  logic [SHARED_W-1:0] bcLowOut,
  output logic [SHARED_W-1:0] bcLowIn,
  input  logic [PORT_W-1:0]   pinIn,
  output logic [PORT_W-1:0]   pinOut,
  output logic [PORT_W-1:0]   pinOe,
  output logic [PORT_W-1:0]   dirQ,
  output logic [PORT_W-1:0]   dataQ
);

  logic                extMode;
  logic [PORT_W-1:0]   dirRst;
  logic [PORT_W-1:0]   syncQ [SYNC_STAGES];
  logic [PORT_W-1:0]   pinSync;
  logic [PORT_W-1:0]   ordMask;
  logic [PORT_W-1:0]   pinState;
  logic [BC_OUT_W-1:0] holdBc;
  logic [SHARED_W-1:0] holdLowOe;
  logic [SHARED_W-1:0] holdLowOut;

  assign extMode = (modePins != MODE_SINGLE);
  assign dirRst  = extMode ? DIR_RST_EXT : DIR_RST_SINGLE;

  // Direction: reloaded by power-on reset and hardware standby only
  always_ff @(posedge clk or negedge rstPorN) begin
    if (!rstPorN)          dirQ <= dirRst;
    else if (hwStandby)    dirQ <= dirRst;
    else if (strobes.wrDir) dirQ <= wrData;
  end

  // Output data: cleared by either reset
  always_ff @(posedge clk or negedge rstPorN) begin
    if (!rstPorN)            dataQ <= '0;
    else if (!manualRstN)    dataQ <= '0;
    else if (strobes.wrData) dataQ <= wrData;
  end

  // Pad input synchronizer
  always_ff @(posedge clk or negedge rstPorN) begin
    if (!rstPorN) begin
      for (int s = 0; s < SYNC_STAGES; s++) syncQ[s] <= '0;
    end else begin
      syncQ[0] <= pinIn;
      for (int s = 1; s < SYNC_STAGES; s++) syncQ[s] <= syncQ[s-1];
    end
  end
  assign pinSync = syncQ[SYNC_STAGES-1];
  assign bcLowIn = pinSync[SHARED_W-1:0];

  // Levels captured at every edge outside software standby
  always_ff @(posedge clk or negedge rstPorN) begin
    if (!rstPorN) begin
      holdBc     <= '0;
      holdLowOe  <= '0;
      holdLowOut <= '0;
    end else if (!swStandby) begin
      holdBc     <= bcOut;
      holdLowOe  <= bcLowOe;
      holdLowOut <= bcLowOut;
    end
  end

  // Per-pin ownership
  for (genvar i = 0; i < PORT_W; i++) begin : g_pin
    if (i == CLK_PIN) begin : g_clk
      assign ordMask[i] = !extMode;
      assign pinOe[i]   = dirQ[i];
      assign pinOut[i]  = extMode ? sysClk : dataQ[i];
    end else if (i >= BC_LO && i <= BC_HI) begin : g_strobe
      logic busOe, busLvl;
      assign busOe      = swStandby ? holdOutputs : 1'b1;
      assign busLvl     = swStandby ? holdBc[i-BC_LO] : bcOut[i-BC_LO];
      assign ordMask[i] = !extMode;
      assign pinOe[i]   = extMode ? busOe  : dirQ[i];
      assign pinOut[i]  = extMode ? busLvl : dataQ[i];
    end else begin : g_shared
      logic owned, busOe, busLvl;
      assign owned      = extMode && bcLowEn[i];
      assign busOe      = swStandby ? (holdOutputs && holdLowOe[i]) : bcLowOe[i];
      assign busLvl     = swStandby ? holdLowOut[i] : bcLowOut[i];
      assign ordMask[i] = !owned;
      assign pinOe[i]   = owned ? busOe  : dirQ[i];
      assign pinOut[i]  = owned ? busLvl : dataQ[i];
    end
    assign pinState[i] = (ordMask[i] && dirQ[i]) ? dataQ[i] : pinSync[i];
  end

  always_comb begin
    unique case (strobes.rdSel)
      RD_DIR:  rdData = DIR_RD_FILL;
      RD_DATA: rdData = dataQ;
      RD_PINS: rdData = pinState;
      default: rdData = '0;
    endcase
  end

endmodule

// File: rtl/altfn_port.sv
module altfn_port
  import altfn_port_pkg::*;
#(
  parameter int                ADDR_W      = 16,
  parameter logic [ADDR_W-1:0] DIR_ADDR    = 16'hFEBE,
  parameter logic [ADDR_W-1:0] DATA_ADDR   = 16'hFF6E,
  parameter logic [ADDR_W-1:0] PIN_ADDR    = 16'hFF5E,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstPorN,
  input  logic              manualRstN,
  input  logic              hwStandby,
  input  logic              swStandby,
  input  logic              holdOutputs,
  input  logic [1:0]        modePins,
  input  logic [15:0]       busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [7:0]        busWrData,
  output logic [7:0]        busRdData,
  input  logic              sysClk,
  input  logic [3:0]        bcOut,
  input  logic [2:0]        bcLowEn,
  input  logic [2:0]        bcLowOe,
  input  logic [2:0]        bcLowOut,
  output logic [2:0]        bcLowIn,
  input  logic [7:0]        pinIn,
  output logic [7:0]        pinOut,
  output logic [7:0]        pinOe
);

  portStrobes_t      strobes;
  logic [PORT_W-1:0] dirBits;
  logic [PORT_W-1:0] dataBits;

  altfn_port_ctrl #(
    .ADDR_W    (ADDR_W),
    .DIR_ADDR  (DIR_ADDR),
    .DATA_ADDR (DATA_ADDR),
    .PIN_ADDR  (PIN_ADDR)
  ) u_ctrl (
    .busAddr (busAddr[ADDR_W-1:0]),
    .busWrEn (busWrEn),
    .busRdEn (busRdEn),
    .strobes (strobes)
  );

  altfn_port_dp #(
    .SYNC_STAGES (SYNC_STAGES)
  ) u_dp (
    .clk         (clk),
    .rstPorN     (rstPorN),
    .manualRstN  (manualRstN),
    .hwStandby   (hwStandby),
    .swStandby   (swStandby),
    .holdOutputs (holdOutputs),
    .modePins    (modePins),
    .strobes     (strobes),
    .wrData      (busWrData),
    .rdData      (busRdData),
    .sysClk      (sysClk),
    .bcOut       (bcOut),
    .bcLowEn     (bcLowEn),
    .bcLowOe     (bcLowOe),
    .bcLowOut    (bcLowOut),
    .bcLowIn     (bcLowIn),
    .pinIn       (pinIn),
    .pinOut      (pinOut),
    .pinOe       (pinOe),
    .dirQ        (dirBits),
    .dataQ       (dataBits)
  );

endmodule

// File: rtl/altfn_port_chk.sv
module altfn_port_chk
  import altfn_port_pkg::*;
#(
  parameter logic [15:0] DIR_ADDR  = 16'hFEBE,
  parameter logic [15:0] DATA_ADDR = 16'hFF6E
) (
  input logic        clk,
  input logic        rstPorN,
  input logic        manualRstN,
  input logic        hwStandby,
  input logic        swStandby,
  input logic        holdOutputs,
  input logic [1:0]  modePins,
  input logic [15:0] busAddr,
  input logic        busWrEn,
  input logic [7:0]  busWrData,
  input logic        sysClk,
  input logic [3:0]  bcOut,
  input logic [7:0]  pinOut,
  input logic [7:0]  pinOe,
  input logic [7:0]  dirBits,
  input logic [7:0]  dataBits
);

  logic extMode;
  assign extMode = (modePins != MODE_SINGLE);

  AST_SINGLE_PASS: assert property (@(posedge clk) disable iff (!rstPorN)
    (modePins == MODE_SINGLE) |-> (pinOe == dirBits && pinOut == dataBits)); // R4

  AST_CLK_PIN: assert property (@(posedge clk) disable iff (!rstPorN)
    extMode |-> (pinOe[7] == dirBits[7] && pinOut[7] == sysClk)); // R5

  AST_STROBE_DRIVE: assert property (@(posedge clk) disable iff (!rstPorN)
    (extMode && !swStandby) |-> (pinOe[6:3] == 4'hF && pinOut[6:3] == bcOut)); // R6

  AST_STBY_FLOAT: assert property (@(posedge clk) disable iff (!rstPorN)
    (extMode && swStandby && !holdOutputs) |-> (pinOe[6:3] == 4'h0)); // R8

  AST_STBY_HOLD: assert property (@(posedge clk) disable iff (!rstPorN)
    (extMode && swStandby && $past(swStandby) && holdOutputs && $past(holdOutputs))
      |-> $stable(pinOut[6:3])); // R8

  AST_HWSTBY_LOAD: assert property (@(posedge clk) disable iff (!rstPorN)
    (hwStandby && $stable(modePins)) |=>
      (dirBits == ((modePins == MODE_SINGLE) ? DIR_RST_SINGLE : DIR_RST_EXT))); // R2

  AST_MANUAL_CLEAR: assert property (@(posedge clk) disable iff (!rstPorN)
    !manualRstN |=> (dataBits == 8'h00)); // R3

  AST_MANUAL_KEEP_DIR: assert property (@(posedge clk) disable iff (!rstPorN)
    (!manualRstN && !hwStandby && !(busWrEn && busAddr == DIR_ADDR)) |=> $stable(dirBits)); // R3

  AST_DATA_WRITE: assert property (@(posedge clk) disable iff (!rstPorN)
    (manualRstN && busWrEn && busAddr == DATA_ADDR) |=> (dataBits == $past(busWrData))); // R9

endmodule

bind altfn_port altfn_port_chk #(
  .DIR_ADDR  (DIR_ADDR),
  .DATA_ADDR (DATA_ADDR)
) u_chk (
  .clk         (clk),
  .rstPorN     (rstPorN),
  .manualRstN  (manualRstN),
  .hwStandby   (hwStandby),
  .swStandby   (swStandby),
  .holdOutputs (holdOutputs),
  .modePins    (modePins),
  .busAddr     (busAddr),
  .busWrEn     (busWrEn),
  .busWrData   (busWrData),
  .sysClk      (sysClk),
  .bcOut       (bcOut),
  .pinOut      (pinOut),
  .pinOe       (pinOe),
  .dirBits     (dirBits),
  .dataBits    (dataBits)
);

// File: tb/sim_altfn_port.sv
`timescale 1ns/1ps
module sim_altfn_port;

  localparam logic [15:0] A_DIR  = 16'hFEBE;
  localparam logic [15:0] A_DATA = 16'hFF6E;
  localparam logic [15:0] A_PINS = 16'hFF5E;

  logic        clk = 1'b0;
  logic        rstPorN, manualRstN, hwStandby, swStandby, holdOutputs;
  logic [1:0]  modePins;
  logic [15:0] busAddr;
  logic        busWrEn, busRdEn;
  logic [7:0]  busWrData, busRdData;
  logic        sysClk;
  logic [3:0]  bcOut;
  logic [2:0]  bcLowEn, bcLowOe, bcLowOut, bcLowIn;
  logic [7:0]  pinIn, pinOut, pinOe;

  int nChecks = 0;
  int nFail   = 0;

  always #5 clk = ~clk;

  altfn_port u0 (
    .clk(clk), .rstPorN(rstPorN), .manualRstN(manualRstN), .hwStandby(hwStandby),
    .swStandby(swStandby), .holdOutputs(holdOutputs), .modePins(modePins),
    .busAddr(busAddr), .busWrEn(busWrEn), .busRdEn(busRdEn), .busWrData(busWrData),
    .busRdData(busRdData), .sysClk(sysClk), .bcOut(bcOut), .bcLowEn(bcLowEn),
    .bcLowOe(bcLowOe), .bcLowOut(bcLowOut), .bcLowIn(bcLowIn), .pinIn(pinIn),
    .pinOut(pinOut), .pinOe(pinOe)
  );

  typedef struct packed {
    logic [1:0] mode;
    logic [7:0] dir;
    logic [7:0] data;
    logic [3:0] bc;
    logic [2:0] en;
    logic [2:0] lOe;
    logic [2:0] lOut;
    logic [7:0] expOe;
    logic [7:0] expOut;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{2'd3, 8'hA5, 8'h3C, 4'h0, 3'b111, 3'b111, 3'b000, 8'hA5, 8'h3C},
    '{2'd3, 8'h0F, 8'hF0, 4'hF, 3'b111, 3'b000, 3'b111, 8'h0F, 8'hF0},
    '{2'd0, 8'h00, 8'hFF, 4'hA, 3'b000, 3'b000, 3'b000, 8'h78, 8'hD7},
    '{2'd1, 8'hFF, 8'h00, 4'h5, 3'b101, 3'b001, 3'b111, 8'hFB, 8'hAD},
    '{2'd2, 8'h07, 8'h02, 4'hF, 3'b010, 3'b010, 3'b000, 8'h7F, 8'hF8},
    '{2'd0, 8'h80, 8'h55, 4'h0, 3'b000, 3'b000, 3'b000, 8'hF8, 8'h85}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [15:0] a, input logic [7:0] d);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
    #1;
  endtask

  task automatic busRead(input logic [15:0] a, output logic [7:0] d);
    busAddr = a; busRdEn = 1'b1;
    #1;
    d = busRdData;
    busRdEn = 1'b0;
  endtask

  task automatic porPulse(input logic [1:0] m);
    modePins = m;
    rstPorN = 1'b0;
    @(negedge clk);
    rstPorN = 1'b1;
    @(negedge clk);
    #1;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin : main
    logic [7:0] rd;
    rstPorN = 1'b0; manualRstN = 1'b1; hwStandby = 1'b0; swStandby = 1'b0;
    holdOutputs = 1'b0; modePins = 2'd3; busAddr = '0; busWrEn = 1'b0;
    busRdEn = 1'b0; busWrData = '0; sysClk = 1'b1; bcOut = '0; bcLowEn = '0;
    bcLowOe = '0; bcLowOut = '0; pinIn = '0;
    repeat (3) @(negedge clk);
    rstPorN = 1'b1;
    @(negedge clk); #1;

    // R1 reset state, single-chip and external-bus
    check("R1 single-chip oe", pinOe, 8'h00);
    busRead(A_DATA, rd);
    check("R1 data reset", rd, 8'h00);
    porPulse(2'd0);
    check("R1 external oe", pinOe, 8'hF8);

    // Vector table: R4 R5 R6 R7 R9
    for (int v = 0; v < NV; v++) begin
      modePins = VECS[v].mode;
      bcOut    = VECS[v].bc;
      bcLowEn  = VECS[v].en;
      bcLowOe  = VECS[v].lOe;
      bcLowOut = VECS[v].lOut;
      busWrite(A_DIR,  VECS[v].dir);
      busWrite(A_DATA, VECS[v].data);
      check("R4/R6/R7 vector oe", pinOe, VECS[v].expOe);
      check("R4/R5/R7 vector out", pinOut, VECS[v].expOut);
      busRead(A_DATA, rd);
      check("R9 data readback", rd, VECS[v].data);
    end

    // R9 read of direction, unmapped read and write
    modePins = 2'd3; bcLowEn = '0;
    busWrite(A_DIR, 8'h80);
    busRead(A_DIR, rd);
    check("R9 direction read fill", rd, 8'hFF);
    busRead(16'h1234, rd);
    check("R9 unmapped read", rd, 8'h00);
    busWrite(16'hFF6F, 8'hEE);
    busWrite(16'hFEBF, 8'h11);
    busRead(A_DATA, rd);
    check("R9 unmapped write data", rd, 8'h55);
    check("R9 unmapped write dir", pinOe, 8'h80);

    // R10 pin-state mix and synchronizer latency
    busWrite(A_DIR, 8'h0F);
    busWrite(A_DATA, 8'h05);
    pinIn = 8'hA0;
    repeat (3) @(negedge clk);
    busRead(A_PINS, rd);
    check("R10 pin state mix", rd, 8'hA5);
    @(negedge clk);
    pinIn = 8'h30;
    @(negedge clk);
    busRead(A_PINS, rd);
    check("R10 after one edge", rd, 8'hA5);
    @(negedge clk);
    busRead(A_PINS, rd);
    check("R10 after two edges", rd, 8'h35);
    modePins = 2'd0;
    pinIn = 8'h05;
    repeat (2) @(negedge clk); #1;
    check("R10 bcLowIn", {5'd0, bcLowIn}, 8'h05);

    // R5 clock pin, R6 ignored direction bits
    sysClk = 1'b0;
    busWrite(A_DIR, 8'h80);
    check("R5 clock level", {7'd0, pinOut[7]}, 8'h00);
    check("R5 clock enable on", {7'd0, pinOe[7]}, 8'h01);
    busWrite(A_DIR, 8'h00);
    check("R5 clock enable off", {7'd0, pinOe[7]}, 8'h00);
    check("R6 direction ignored", {4'd0, pinOe[6:3]}, 8'h0F);
    sysClk = 1'b1;

    // R2 hardware standby
    modePins = 2'd3;
    busWrite(A_DIR, 8'hFF);
    check("R2 before standby", pinOe, 8'hFF);
    hwStandby = 1'b1;
    @(negedge clk); #1;
    check("R2 reload", pinOe, 8'h00);
    busWrite(A_DIR, 8'hFF);
    hwStandby = 1'b0;
    #1;
    check("R2 write blocked", pinOe, 8'h00);

    // R3 manual reset and software standby
    busWrite(A_DIR, 8'h3C);
    busWrite(A_DATA, 8'h5A);
    manualRstN = 1'b0;
    @(negedge clk);
    manualRstN = 1'b1;
    #1;
    busRead(A_DATA, rd);
    check("R3 data cleared", rd, 8'h00);
    check("R3 direction kept", pinOe, 8'h3C);
    swStandby = 1'b1;
    repeat (2) @(negedge clk);
    swStandby = 1'b0;
    #1;
    check("R3 standby keeps direction", pinOe, 8'h3C);

    // R8 software standby hold and float
    modePins = 2'd0;
    busWrite(A_DIR, 8'h00);
    bcOut = 4'h9; bcLowEn = 3'b001; bcLowOe = 3'b001; bcLowOut = 3'b001;
    @(negedge clk);
    swStandby = 1'b1; holdOutputs = 1'b1;
    @(negedge clk);
    bcOut = 4'h6; bcLowOut = 3'b000;
    @(negedge clk); #1;
    check("R8 held strobes", {4'd0, pinOut[6:3]}, 8'h09);
    check("R8 held enables", {4'd0, pinOe[6:3]}, 8'h0F);
    check("R8 held shared pin", {7'd0, pinOut[0]}, 8'h01);
    holdOutputs = 1'b0;
    #1;
    check("R8 float strobes", {4'd0, pinOe[6:3]}, 8'h00);
    check("R8 float shared pin", {7'd0, pinOe[0]}, 8'h00);
    swStandby = 1'b0;
    #1;
    check("R8 release enables", {4'd0, pinOe[6:3]}, 8'h0F);
    check("R8 release levels", {4'd0, pinOut[6:3]}, 8'h06);

    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule